// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block decides what to do with a 512-byte flash data block once its 24-bit Hamming code has been recomputed. It takes the code stored in the spare area and the freshly computed code, XORs them into a syndrome, and sorts the outcome into one of four classes: clean, one data bit flipped and correctable, one bit flipped inside the stored code only, or beyond repair. For the correctable class it names the flipped bit by a 9-bit byte index and a 3-bit bit index, and it pulses a correction strobe so that a separate buffer stage can invert that bit. The block corrects at most one bit per 512-byte block, using 3 code bytes.

The code uses complementary parity pairs. A single data-bit error flips exactly one bit of every adjacent pair of the syndrome, and the upper bit of each pair then spells out the error position. An optional mode treats a stored code of all ones as a page that was erased and never programmed, and reports it as clean.

A caller presents both codes and the erased-page option, raises `start` for one cycle, and reads the result one cycle later while `resultValid` is high. The result stays on the outputs until the next start.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: After reset `resultValid`, `fixStrobe`, `status`, `byteIdx` and `bitIdx` are all zero.
- R2: `resultValid` is high for exactly the one cycle after a cycle with `start` high. `status`, `byteIdx` and `bitIdx` change only in that cycle and are held otherwise. Byte k of a code is bits [8k+7:8k].
- R3: When the syndrome (stored XOR computed) is zero, `status` is 00 (clean). This holds even when the erased-page option is on and the stored code is all ones.
- R4: When the stored code is 0xFFFFFF and `ignoreErased` is 1, `status` is 00 for any computed code. When `ignoreErased` is 0, the same codes go through the normal classification.
- R5: When every syndrome bit pair (bits 2p+1 and 2p) holds exactly one set bit, `status` is 01 (corrected).
- R6: For status 01, `byteIdx` bits 3..0 are syndrome bits 7,5,3,1, bits 7..4 are syndrome bits 15,13,11,9, and bit 8 is syndrome bit 17. `bitIdx` bits 0,1,2 are syndrome bits 19,21,23.
- R7: When the syndrome has exactly one bit set, `status` is 10 (error in the stored code only, data left untouched).
- R8: Any other nonzero syndrome gives `status` 11 (uncorrectable).
- R9: `fixStrobe` is high exactly when `resultValid` is high and `status` is 01.
- R10: Whenever `status` is not 01, `byteIdx` and `bitIdx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to classify the present codes |
| ignoreErased | input | 1 | Report an all-ones stored code as clean |
| storedCode | input | 24 | Code read from the spare area, byte 0 in bits 7:0 |
| calcCode | input | 24 | Code computed over the data block |
| resultValid | output | 1 | Result valid, one cycle after start |
| status | output | 2 | 00 clean, 01 corrected, 10 code-only error, 11 uncorrectable |
| byteIdx | output | 9 | Byte index of the flipped data bit |
| bitIdx | output | 3 | Bit index of the flipped data bit |
| fixStrobe | output | 1 | Pulse asking the buffer stage to flip the named bit |

## Verification
The codes are driven with equal values (clean), with syndromes built from a random byte and bit position (correctable, which also checks the index extraction), with a single random syndrome bit (code-only error), and with random syndromes that are almost always uncorrectable. Erased pages are driven with the option on and off, so that the erased rule is told apart from a plain mismatch, and an all-ones code matched by an all-ones computed code checks that the zero-syndrome rule wins. Corner positions such as byte 0 bit 0 and byte 511 bit 7 show whether each index bit comes from the right syndrome bit. The bench also checks that the result holds when no start arrives.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXED    = 2'b01,
    ST_CODE_ERR = 2'b10,
    ST_FATAL    = 2'b11
  } eccStatus_t;

  typedef struct packed {
    logic capture;
  } eccCtrl_t;
endpackage

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output eccCtrl_t ctrl,
  output logic     resultValid
);
  always_comb begin
    ctrl.capture = start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= start;
  end
endmodule

// File: rtl/ecc_fix_datapath.sv
module ecc_fix_datapath
  import ecc_fix_pkg::*;
#(
  parameter int CODE_W    = 24,
  parameter int BIT_IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  eccCtrl_t                ctrl,
  input  logic                    ignoreErased,
  input  logic [CODE_W-1:0]       storedCode,
  input  logic [CODE_W-1:0]       calcCode,
  output logic [1:0]              status,
  output logic [CODE_W/2-BIT_IDX_W-1:0] byteIdx,
  output logic [BIT_IDX_W-1:0]    bitIdx
);
  localparam int PAIRS      = CODE_W / 2;
  localparam int BYTE_IDX_W = PAIRS - BIT_IDX_W;

  logic [CODE_W-1:0] syndrome;
  logic [PAIRS-1:0]  pairSplit;
  logic [PAIRS-1:0]  oddBits;
  logic              isZero, isErased, isSingle, allSplit;
  eccStatus_t        nextStatus;

  assign syndrome = storedCode ^ calcCode;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pairSplit[p] = syndrome[2*p+1] ^ syndrome[2*p];
    assign oddBits[p]   = syndrome[2*p+1];
  end

  assign isZero   = (syndrome == '0);
  assign isErased = ignoreErased && (storedCode == {CODE_W{1'b1}});
  assign allSplit = &pairSplit;
  assign isSingle = ((syndrome & (syndrome - 1'b1)) == '0);

  always_comb begin
    if (isZero || isErased) nextStatus = ST_CLEAN;
    else if (allSplit)      nextStatus = ST_FIXED;
    else if (isSingle)      nextStatus = ST_CODE_ERR;
    else                    nextStatus = ST_FATAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= ST_CLEAN;
      byteIdx <= '0;
      bitIdx  <= '0;
    end else if (ctrl.capture) begin
      status <= nextStatus;
      if (nextStatus == ST_FIXED) begin
        byteIdx <= oddBits[BYTE_IDX_W-1:0];
        bitIdx  <= oddBits[PAIRS-1:BYTE_IDX_W];
      end else begin
        byteIdx <= '0;
        bitIdx  <= '0;
      end
    end
  end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_fix_pkg::*;
#(
  parameter int CODE_W    = 24,
  parameter int BIT_IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          ignoreErased,
  input  logic [CODE_W-1:0]             storedCode,
  input  logic [CODE_W-1:0]             calcCode,
  output logic                          resultValid,
  output logic [1:0]                    status,
  output logic [CODE_W/2-BIT_IDX_W-1:0] byteIdx,
  output logic [BIT_IDX_W-1:0]          bitIdx,
  output logic                          fixStrobe
);
  eccCtrl_t ctrl;

  ecc_fix_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctrl(ctrl), .resultValid(resultValid)
  );

  ecc_fix_datapath #(.CODE_W(CODE_W), .BIT_IDX_W(BIT_IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .ignoreErased(ignoreErased),
    .storedCode(storedCode), .calcCode(calcCode),
    .status(status), .byteIdx(byteIdx), .bitIdx(bitIdx)
  );

  assign fixStrobe = resultValid && (status == ST_FIXED);
endmodule

// File: rtl/ecc_fix_checker.sv
module ecc_fix_checker #(
  parameter int CODE_W    = 24,
  parameter int BIT_IDX_W = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          start,
  input logic                          ignoreErased,
  input logic [CODE_W-1:0]             storedCode,
  input logic [CODE_W-1:0]             calcCode,
  input logic                          resultValid,
  input logic [1:0]                    status,
  input logic [CODE_W/2-BIT_IDX_W-1:0] byteIdx,
  input logic [BIT_IDX_W-1:0]          bitIdx,
  input logic                          fixStrobe
);
  assert_valid_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resultValid);
  assert_valid_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resultValid && $stable(status) && $stable(byteIdx) && $stable(bitIdx));
  assert_zero_syndrome_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && storedCode == calcCode) |=> status == 2'b00);
  assert_erased_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    (start && ignoreErased && (&storedCode)) |=> status == 2'b00);
  assert_single_code_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && $onehot(storedCode ^ calcCode) && !(ignoreErased && (&storedCode)))
      |=> status == 2'b10);
  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    fixStrobe == (resultValid && status == 2'b01));
  assert_idle_indices_R10: assert property (@(posedge clk) disable iff (!rstN)
    (status != 2'b01) |-> (byteIdx == '0 && bitIdx == '0));
endmodule

bind ecc_syndrome_corrector ecc_fix_checker #(.CODE_W(CODE_W), .BIT_IDX_W(BIT_IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .ignoreErased(ignoreErased),
  .storedCode(storedCode), .calcCode(calcCode), .resultValid(resultValid),
  .status(status), .byteIdx(byteIdx), .bitIdx(bitIdx), .fixStrobe(fixStrobe)
);

// File: tb/tb_ecc_syndrome_corrector.sv
module tb_ecc_syndrome_corrector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        ignoreErased = 1'b0;
  logic [23:0] storedCode = '0;
  logic [23:0] calcCode = '0;
  logic        resultValid;
  logic [1:0]  status;
  logic [8:0]  byteIdx;
  logic [2:0]  bitIdx;
  logic        fixStrobe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_syndrome_corrector dut (
    .clk(clk), .rstN(rstN), .start(start), .ignoreErased(ignoreErased),
    .storedCode(storedCode), .calcCode(calcCode), .resultValid(resultValid),
    .status(status), .byteIdx(byteIdx), .bitIdx(bitIdx), .fixStrobe(fixStrobe)
  );

  // Builds a syndrome for a single data-bit error at (byte, bit).
  function automatic logic [23:0] make_syndrome(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] pos;
    logic [23:0] s;
    pos = {k, b};
    for (int p = 0; p < 12; p++) begin
      s[2*p+1] = pos[p];
      s[2*p]   = ~pos[p];
    end
    return s;
  endfunction

  // Expected {status, byteIdx, bitIdx} from the requirements.
  function automatic logic [13:0] model(input logic [23:0] st, input logic [23:0] ca, input logic ign);
    logic [23:0] s;
    logic ok;
    logic [8:0] b;
    logic [2:0] k;
    int ones;
    s = st ^ ca;
    if (s == 0) return {2'b00, 12'd0};
    if (ign && st == 24'hFFFFFF) return {2'b00, 12'd0};
    ok = 1'b1;
    ones = 0;
    for (int i = 0; i < 24; i++) ones += int'(s[i]);
    for (int p = 0; p < 12; p++) if (s[2*p+1] == s[2*p]) ok = 1'b0;
    if (ok) begin
      b = {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]};
      k = {s[23], s[21], s[19]};
      return {2'b01, b, k};
    end
    if (ones == 1) return {2'b10, 12'd0};
    return {2'b11, 12'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [23:0] st, input logic [23:0] ca, input logic ign, input string req);
    logic [13:0] e;
    e = model(st, ca, ign);
    storedCode = st; calcCode = ca; ignoreErased = ign; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " resultValid R2"}, 32'(resultValid), 32'd1);
    check({req, " status"}, 32'(status), 32'(e[13:12]));
    check({req, " byteIdx R6 R10"}, 32'(byteIdx), 32'(e[11:3]));
    check({req, " bitIdx R6 R10"}, 32'(bitIdx), 32'(e[2:0]));
    check({req, " fixStrobe R9"}, 32'(fixStrobe), 32'(e[13:12] == 2'b01));
    storedCode = ~st; calcCode = st;
    @(negedge clk);
    check({req, " hold R2"}, {resultValid, fixStrobe, status, byteIdx, bitIdx},
          {1'b0, 1'b0, e[13:12], e[11:0]});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("reset R1", {resultValid, fixStrobe, status, byteIdx, bitIdx}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("post-reset idle R1", {resultValid, fixStrobe, status}, 32'd0);

    run_case(24'h123456, 24'h123456, 1'b0, "clean R3");
    run_case(24'hFFFFFF, 24'hFFFFFF, 1'b1, "erased zero-syndrome R3");
    run_case(24'hFFFFFF, 24'h00A5C3, 1'b1, "erased ignored R4");
    run_case(24'hFFFFFF, 24'h00A5C3, 1'b0, "erased not ignored R4 R8");
    run_case(24'hFFFFFF, 24'hFFFFFF ^ make_syndrome(9'd77, 3'd2), 1'b1, "erased over fix R4");
    run_case(24'hFFFFFF, 24'hFFFFFF ^ make_syndrome(9'd77, 3'd2), 1'b0, "erased off fix R5");
    run_case(24'h000000, make_syndrome(9'd0, 3'd0), 1'b0, "fix byte0 bit0 R5 R6");
    run_case(24'h5A5A5A, 24'h5A5A5A ^ make_syndrome(9'd511, 3'd7), 1'b0, "fix byte511 bit7 R5 R6");
    run_case(24'h000000, make_syndrome(9'd256, 3'd4), 1'b0, "fix byte256 R6");
    run_case(24'h0F0F0F, 24'h0F0F0F ^ 24'h000001, 1'b0, "code bit0 R7");
    run_case(24'h0F0F0F, 24'h0F0F0F ^ 24'h800000, 1'b0, "code bit23 R7");
    run_case(24'h000000, 24'h000003, 1'b0, "two bits R8");
    run_case(24'h000000, make_syndrome(9'd3, 3'd1) ^ 24'h000004, 1'b0, "broken pair R8");

    for (int n = 0; n < 300; n++) begin
      logic [23:0] st, ca;
      logic ign;
      int kind;
      st = 24'($urandom);
      ign = 1'($urandom);
      kind = int'($urandom_range(0, 4));
      case (kind)
        0: ca = st;
        1: ca = st ^ make_syndrome(9'($urandom), 3'($urandom));
        2: ca = st ^ (24'd1 << $urandom_range(0, 23));
        3: ca = 24'($urandom);
        default: begin st = 24'hFFFFFF; ca = 24'($urandom); end
      endcase
      run_case(st, ca, ign, "random R3 R4 R5 R6 R7 R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule